// File: doc/BRIEF.md
# Burst-Capture Image Sensor Sequencer

This block drives the digital timing of an image sensor that keeps every pixel's charge inside the pixel during a particle bunch train and converts it only after the train has ended. A trigger marks the start of the train. The sequencer then pulses a global photogate/transfer strobe at a programmable interval. Each pulse moves the freshly collected charge of every pixel one step into that pixel's own storage register. After as many pulses as the register has cells, the capture burst is over.

Next comes the quiet period. The sequencer walks the rows in ascending order and holds one row-select line high for the whole time of a row. Inside a row it first strobes the reset gate of the sense node. For every stored sample it then gives one conversion strobe to the column-parallel converters, followed one clock later by one storage-register shift. Each conversion slot is flagged with a sample-valid pulse that carries the row and the sample index. A done pulse closes the burst.

Both the capture interval and the readout slot length are counted in system clocks. At a 100 MHz clock, interval 5000 gives the 20 kHz capture rate and length 100 gives the 1 MHz conversion rate. The array height and the register depth are parameters.

Top module: `burst_seq`

## Requirements
- R1: After reset the block is idle: busy, done, overrun and every strobe, row-select and sample-valid output are low.
- R2: A trigger sampled while idle starts a burst: busy is high in the cycle after that clock edge, and the capture interval and slot length are latched at that edge.
- R3: With capture interval C, the n-th transfer strobe (n = 1..DEPTH) is a single-cycle pulse in the cycle that follows the (n·C−1)-th clock edge after the accepting edge. Exactly DEPTH strobes are issued per burst.
- R4: While capture is running, no row-select, reset-gate, conversion, shift or sample-valid output is asserted.
- R5: Readout starts at edge DEPTH·C. Rows are read in ascending order from 0 to ROWS−1. During a row exactly one row-select bit, the bit at the row index, is high for (DEPTH+1)·S cycles, where S is the slot length.
- R6: Each row is split into DEPTH+1 slots of S cycles. The reset gate pulses in the last cycle of slot 0, and a conversion strobe pulses in the second-to-last cycle of each slot 1..DEPTH.
- R7: A storage-register shift pulses in the cycle right after every conversion strobe, and row-select does not change between the two.
- R8: Sample-valid pulses together with each conversion strobe. It carries the current row index and sample index k−1 for slot k, so samples come 0..DEPTH−1 in order.
- R9: In the cycle after the last shift of the last row, done pulses for one cycle and busy is low.
- R10: A trigger that arrives while busy does not change the running sequence. It sets the overrun flag from the next cycle on, and the flag stays set until reset.
- R11: A capture interval or slot length below 2 behaves exactly like a value of 2.
- R12: Changes to the configuration inputs during a burst have no effect on that burst.
- R13: With a 100 MHz clock, interval 5000 and slot length 100 yield 20 kHz transfer strobes and 1 MHz conversion strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Train-start trigger |
| cap_div_i | input | CAP_DW | Capture interval in clocks |
| rd_div_i | input | RD_DW | Readout slot length in clocks |
| pg_o | output | 1 | Global photogate/transfer strobe |
| rowsel_o | output | ROWS | One-hot row select |
| rg_o | output | 1 | Reset-gate strobe |
| conv_o | output | 1 | Column converter start strobe |
| shift_o | output | 1 | Storage register shift strobe |
| smp_vld_o | output | 1 | Sample-valid pulse |
| row_o | output | idx_w(ROWS) | Row index of the current slot |
| smp_o | output | idx_w(DEPTH) | Sample index of the current slot |
| done_o | output | 1 | Whole-array-read pulse |
| busy_o | output | 1 | Capture or readout in progress |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
Every output is due at a fixed cycle offset from the edge that accepts the trigger. Let t be the number of edges since that edge. The transfer strobe falls where t mod C equals C−1. After DEPTH·C, the readout position splits into row, slot and phase through integer division by S. Done and idle follow at DEPTH·C + ROWS·(DEPTH+1)·S, and an overrun shows one cycle after the late trigger. The bench works out these offsets on its own. It drives inputs on the falling edge and compares every output at each falling edge against the value computed for that t, so each check lands in exactly the cycle where the result is due.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CAPT = 2'd1,
      PH_READ = 2'd2
   } phase_e;

   // index width that can hold 0..n-1, never less than one bit
   function automatic int idx_w(input int n);
      if (n <= 1) return 1;
      return $clog2(n);
   endfunction

endpackage

// File: rtl/bseq_tick.sv
module bseq_tick #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic [W-1:0] div_i,
   output logic         last_o,
   output logic         pre_o
);

   localparam logic [W-1:0] ONE = W'(1);
   localparam logic [W-1:0] TWO = W'(2);

   if (W < 2) begin : g_bad_w
      $error("bseq_tick: W must be at least 2");
   end

   logic [W-1:0] cnt_q;

   assign last_o = run_i && (cnt_q == div_i - ONE);
   assign pre_o  = run_i && (cnt_q == div_i - TWO);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!run_i || last_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + ONE;
   end

   // R11: the divider handed in by the controller is clamped, so the count stays below it
   a_r11_cnt_below_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (cnt_q < div_i));

endmodule

// File: rtl/bseq_walk.sv
module bseq_walk
   import bseq_pkg::*;
#(
   parameter int ROWS  = 16,
   parameter int DEPTH = 5,
   localparam int SLW  = idx_w(DEPTH + 1),
   localparam int RW   = idx_w(ROWS)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           clr_i,
   input  logic           step_i,
   output logic [SLW-1:0] slot_o,
   output logic [RW-1:0]  row_o,
   output logic           end_o
);

   localparam logic [SLW-1:0] SLOT_LAST = SLW'(DEPTH);
   localparam logic [RW-1:0]  ROW_LAST  = RW'(ROWS - 1);

   logic [SLW-1:0] slot_q;
   logic [RW-1:0]  row_q;

   assign slot_o = slot_q;
   assign row_o  = row_q;
   assign end_o  = (slot_q == SLOT_LAST) && (row_q == ROW_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slot_q <= '0;
         row_q  <= '0;
      end else if (clr_i) begin
         slot_q <= '0;
         row_q  <= '0;
      end else if (step_i) begin
         if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
            row_q  <= (row_q == ROW_LAST) ? '0 : row_q + RW'(1);
         end else begin
            slot_q <= slot_q + SLW'(1);
         end
      end
   end

   // R8: slot index never passes the last sample slot
   a_r8_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_q <= SLOT_LAST);

   // R5: leaving a row moves to the next higher row
   a_r5_row_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !clr_i && slot_q == SLOT_LAST && !end_o) |=> (row_q == $past(row_q) + RW'(1)));

endmodule

// File: rtl/bseq_rowdec.sv
module bseq_rowdec #(
   parameter int ROWS = 16,
   parameter int RW   = 4
) (
   input  logic            en_i,
   input  logic [RW-1:0]   row_i,
   output logic [ROWS-1:0] sel_o
);

   if (ROWS > (1 << RW)) begin : g_bad_rw
      $error("bseq_rowdec: RW too narrow for ROWS");
   end

   for (genvar i = 0; i < ROWS; i++) begin : g_line
      assign sel_o[i] = en_i && (row_i == RW'(i));
   end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import bseq_pkg::*;
#(
   parameter int ROWS   = 16,
   parameter int DEPTH  = 5,
   parameter int CAP_DW = 16,
   parameter int RD_DW  = 8,
   localparam int RW    = idx_w(ROWS),
   localparam int SW    = idx_w(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trig_i,
   input  logic [CAP_DW-1:0] cap_div_i,
   input  logic [RD_DW-1:0]  rd_div_i,
   output logic              pg_o,
   output logic [ROWS-1:0]   rowsel_o,
   output logic              rg_o,
   output logic              conv_o,
   output logic              shift_o,
   output logic              smp_vld_o,
   output logic [RW-1:0]     row_o,
   output logic [SW-1:0]     smp_o,
   output logic              done_o,
   output logic              busy_o,
   output logic              ovr_o
);

   localparam int DW  = (CAP_DW > RD_DW) ? CAP_DW : RD_DW;
   localparam int SLW = idx_w(DEPTH + 1);
   localparam int CNW = idx_w(DEPTH);
   localparam logic [CNW-1:0] CAPN_LAST = CNW'(DEPTH - 1);

   if (ROWS < 1)   begin : g_bad_rows  $error("burst_seq: ROWS must be >= 1");  end
   if (DEPTH < 1)  begin : g_bad_depth $error("burst_seq: DEPTH must be >= 1"); end
   if (CAP_DW < 2) begin : g_bad_cdw   $error("burst_seq: CAP_DW must be >= 2"); end
   if (RD_DW < 2)  begin : g_bad_rdw   $error("burst_seq: RD_DW must be >= 2"); end

   phase_e         ph_q;
   logic [DW-1:0]  cd_q, rd_q, div_sel;
   logic [CNW-1:0] capn_q;
   logic           done_q, ovr_q;
   logic           tick_last, tick_pre;
   logic [SLW-1:0] slot;
   logic [RW-1:0]  row;
   logic           walk_end;
   logic           in_read, in_capt;

   assign in_read = (ph_q == PH_READ);
   assign in_capt = (ph_q == PH_CAPT);
   assign div_sel = in_capt ? cd_q : rd_q;

   bseq_tick #(.W(DW)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ph_q != PH_IDLE),
      .div_i  (div_sel),
      .last_o (tick_last),
      .pre_o  (tick_pre)
   );

   bseq_walk #(.ROWS(ROWS), .DEPTH(DEPTH)) u_walk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!in_read),
      .step_i (in_read && tick_last),
      .slot_o (slot),
      .row_o  (row),
      .end_o  (walk_end)
   );

   bseq_rowdec #(.ROWS(ROWS), .RW(RW)) u_rowdec (
      .en_i  (in_read),
      .row_i (row),
      .sel_o (rowsel_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         cd_q   <= DW'(2);
         rd_q   <= DW'(2);
         capn_q <= '0;
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (trig_i) begin
                  ph_q   <= PH_CAPT;
                  capn_q <= '0;
                  cd_q   <= (cap_div_i < CAP_DW'(2)) ? DW'(2) : DW'(cap_div_i);
                  rd_q   <= (rd_div_i < RD_DW'(2))   ? DW'(2) : DW'(rd_div_i);
               end
            end
            PH_CAPT: begin
               if (tick_last) begin
                  if (capn_q == CAPN_LAST) ph_q <= PH_READ;
                  else                     capn_q <= capn_q + CNW'(1);
               end
            end
            PH_READ: begin
               if (tick_last && walk_end) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
         if (trig_i && ph_q != PH_IDLE) ovr_q <= 1'b1;
      end
   end

   assign pg_o      = in_capt && tick_last;
   assign rg_o      = in_read && tick_last && (slot == '0);
   assign conv_o    = in_read && tick_pre && (slot != '0);
   assign shift_o   = in_read && tick_last && (slot != '0);
   assign smp_vld_o = conv_o;
   assign row_o     = row;
   assign smp_o     = (slot != '0) ? SW'(slot - SLW'(1)) : '0;
   assign done_o    = done_q;
   assign busy_o    = (ph_q != PH_IDLE);
   assign ovr_o     = ovr_q;

   // R4: nothing of the readout runs while charge is being captured
   a_r4_quiet_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_capt |-> (rowsel_o == '0 && !conv_o && !rg_o && !shift_o));

   // R5: never more than one row selected
   a_r5_rowsel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rowsel_o));

   // R7: a shift follows every conversion, under the same row select
   a_r7_shift_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |=> shift_o);
   a_r7_row_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_o |=> $stable(rowsel_o));

   // R9: done comes right after the final shift, with the block idle
   a_r9_done_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ($past(shift_o) && !busy_o));

   // R10: the overrun flag is sticky
   a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o |=> ovr_o);

   // R10: a late trigger does not cut a running burst short
   a_r10_trig_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && trig_i && !(in_read && tick_last && walk_end)) |=> busy_o);

endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS   = 16;
   localparam int DEPTH  = 5;
   localparam int CAP_DW = 16;
   localparam int RD_DW  = 8;
   localparam int RW     = $clog2(ROWS);
   localparam int SW     = $clog2(DEPTH);
   localparam int WATCHDOG = 190000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              trig;
   logic [CAP_DW-1:0] cap_div;
   logic [RD_DW-1:0]  rd_div;
   logic              pg, rg, conv, shift, vld, done, busy, ovr;
   logic [ROWS-1:0]   rowsel;
   logic [RW-1:0]     row;
   logic [SW-1:0]     smp;

   int n_chk = 0;
   int n_err = 0;
   int cur_t = 0;
   bit exp_ovr = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_seq #(.ROWS(ROWS), .DEPTH(DEPTH), .CAP_DW(CAP_DW), .RD_DW(RD_DW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .cap_div_i(cap_div), .rd_div_i(rd_div),
      .pg_o(pg), .rowsel_o(rowsel), .rg_o(rg), .conv_o(conv), .shift_o(shift),
      .smp_vld_o(vld), .row_o(row), .smp_o(smp), .done_o(done), .busy_o(busy), .ovr_o(ovr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, cur_t, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // caller stands at a falling edge; trig_at < 0 means no late trigger
   task automatic burst(input int cd_cfg, input int rd_cfg, input bit poke,
                        input int trig_at, input string cap_tag);
      int cd, rd, capl, lrd, total;
      cd    = (cd_cfg < 2) ? 2 : cd_cfg;
      rd    = (rd_cfg < 2) ? 2 : rd_cfg;
      capl  = DEPTH * cd;
      lrd   = ROWS * (DEPTH + 1) * rd;
      total = capl + lrd;
      trig    = 1'b1;
      cap_div = CAP_DW'(cd_cfg);
      rd_div  = RD_DW'(rd_cfg);
      for (int t = 0; t <= total; t++) begin
         bit e_pg, e_rg, e_cv, e_sh, e_rd;
         int r, s, u, g, ph;
         @(negedge clk);
         trig  = 1'b0;
         cur_t = t;
         e_pg = 0; e_rg = 0; e_cv = 0; e_sh = 0; e_rd = 0; r = 0; s = 0;
         if (t < capl) begin
            e_pg = ((t % cd) == cd - 1);
         end else if (t < total) begin
            u  = t - capl;
            g  = u / rd;
            ph = u % rd;
            r  = g / (DEPTH + 1);
            s  = g % (DEPTH + 1);
            e_rd = 1;
            e_rg = (s == 0) && (ph == rd - 1);
            e_cv = (s >= 1) && (ph == rd - 2);
            e_sh = (s >= 1) && (ph == rd - 1);
         end
         if (trig_at >= 0 && t == trig_at + 1) exp_ovr = 1'b1;
         if (t == 0) chk("R2", int'(busy), 1);
         chk(cap_tag, int'(pg), int'(e_pg));
         chk((t < capl) ? "R4" : "R5", int'(rowsel), e_rd ? (1 << r) : 0);
         chk((t < capl) ? "R4" : "R6", int'(rg), int'(e_rg));
         chk((t < capl) ? "R4" : "R6", int'(conv), int'(e_cv));
         chk("R7", int'(shift), int'(e_sh));
         chk("R8", int'(vld), int'(e_cv));
         if (e_cv) begin
            chk("R8", int'(row), r);
            chk("R8", int'(smp), s - 1);
         end
         chk("R9", int'(done), (t == total) ? 1 : 0);
         chk("R9", int'(busy), (t < total) ? 1 : 0);
         chk("R10", int'(ovr), int'(exp_ovr));
         if (poke) begin
            cap_div = CAP_DW'($urandom);
            rd_div  = RD_DW'($urandom);
         end
         if (t == trig_at) trig = 1'b1;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      summary();
   end

   initial begin
      void'($urandom(32'h5eed));
      rst_n = 1'b0; trig = 1'b0; cap_div = '0; rd_div = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      chk("R1", int'(busy), 0);
      chk("R1", int'(pg | rg | conv | shift | vld | done), 0);
      chk("R1", int'(rowsel), 0);
      chk("R1", int'(ovr), 0);

      burst(4, 3, 1'b0, -1, "R3");
      burst(0, 1, 1'b0, -1, "R11");
      burst(3, 2, 1'b1, 10, "R12");
      for (int i = 0; i < 6; i++) begin
         int cd, rd, ta;
         cd = 2 + int'($urandom % 30);
         rd = int'($urandom % 9);
         ta = ($urandom % 2 == 0) ? -1 : 1 + int'($urandom % (2 * DEPTH));
         burst(cd, rd, 1'($urandom % 2), ta, "R12");
      end
      // R13: 100 MHz clock, 20 kHz capture and 1 MHz conversion
      burst(5000, 100, 1'b0, -1, "R13");

      // R10: overrun clears only on reset
      @(negedge clk);
      cur_t = -1;
      chk("R10", int'(ovr), 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", int'(ovr), 0);
      chk("R1", int'(busy), 0);
      summary();
   end

endmodule